// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge Handshake

This block gathers up to sixteen interrupt request lines and drives a single interrupt output toward a processor. Every line has its own configuration word that chooses between edge and level sensitivity and assigns a four-bit priority. A mask word can silence any line. Lines that have fired are held as pending. Among the pending, unmasked lines the controller picks the one with the highest priority and then raises the interrupt output. The winner is published two ways: as a one-hot word and as a binary index.

While the output is high, the published winner stays fixed. Software services the request and then writes a one to an agreement bit in the control word. That bit only takes effect once the serviced line's pending bit has gone away or the line has been masked. When it does take effect, the output drops, the winner words clear, the agreement bit clears itself, and arbitration runs again. For an edge-sensitive line, reading either winner word clears its pending bit. A level-sensitive line stays pending for as long as its input is high.

Access is through a simple word-addressed register bus. Read data appears on the cycle after the read strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_o is low, the mask word (address 0x00) reads all ones for the implemented sources, every configuration word reads 0, both winner words read 0 and the control word reads 0.
- R2: The configuration word of source i is at word address 0x10+i. Bit 5 selects edge sensitivity (1 = edge, 0 = level) and bits 4:1 hold the priority; every other bit is ignored on write and reads as 0. Mask bit i (address 0x00) set to 1 masks source i.
- R3: A level-sensitive source is pending exactly when its input was high at the previous clock edge. Reading the winner words does not clear it.
- R4: An edge-sensitive source becomes pending on a rising edge of its input. It stays pending until the one-hot winner word (0x01) or the index word (0x02) is read while it is the published winner. A rising edge in the same cycle as such a read keeps it pending.
- R5: With irq_o low, the controller picks the pending, unmasked source with the numerically highest priority, taking the lowest index on a tie. It then raises irq_o, sets bit i of the one-hot word and sets the index word to i.
- R6: While irq_o is high, the winner words do not change, even when a higher-priority source becomes pending.
- R7: Writing 1 to bit 0 of the control word (0x03) releases the request if the winner's pending bit is clear or the winner is masked. irq_o then falls, the winner words read 0, and a new winner may be raised afterwards.
- R8: While the winner is still pending and unmasked, the agreement bit stays set (control bit 0 reads 1) and irq_o stays high. The agreement takes effect as soon as the condition is met, and the bit then clears itself.
- R9: A masked source never raises irq_o. The raw pending word (0x04) shows pending sources regardless of the mask.
- R10: Read data is registered and valid on the cycle after the read strobe. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Interrupt request lines |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench drives a three-way race in which two sources tie at the top priority. A design that breaks the tie toward the higher index, or that compares priorities the wrong way round, reports the wrong index. It writes the agreement bit while the winner is still pending. A design that releases without checking the condition drops irq_o too early, and one that discards the pending agreement never drops it. It raises a higher-priority source while a request is held, which exposes a winner that is not frozen. It lines up a read of the index word with a fresh rising edge on the same source, which catches a design that lets the read clear win and so loses a new interrupt. Level sources are read repeatedly to show that reads leave them pending, and masked sources are shown pending but silent.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // Priority field width is fixed by the configuration word layout.
  localparam int PRIO_W      = 4;
  localparam int CFG_PRIO_LO = 1;
  localparam int CFG_EDGE    = CFG_PRIO_LO + PRIO_W;  // bit 5

  // Word addresses
  localparam int A_MASK     = 0;
  localparam int A_WIN_HOT  = 1;
  localparam int A_WIN_IDX  = 2;
  localparam int A_CTRL     = 3;
  localparam int A_PEND     = 4;
  localparam int A_CFG_BASE = 16;
endpackage

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] edge_sel,
  input  logic [NUM_SRC-1:0] clr_req,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] src_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic rise;
    assign rise = src_in[i] & ~src_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        src_q[i] <= 1'b0;
        pend[i]  <= 1'b0;
      end else begin
        src_q[i] <= src_in[i];
        if (!edge_sel[i])   pend[i] <= src_in[i];
        else if (rise)      pend[i] <= 1'b1;
        else if (clr_req[i]) pend[i] <= 1'b0;
      end
    end

    // R4: a rising edge always leaves an edge source pending
    p_edge_sets_r4: assert property (@(posedge clk) disable iff (rst)
      (edge_sel[i] && src_in[i] && !src_q[i]) |=> pend[i]);
    // R3: a level source tracks its input one edge later
    p_level_follow_r3: assert property (@(posedge clk) disable iff (rst)
      !edge_sel[i] |=> (pend[i] == $past(src_in[i])));
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 4,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]             elig,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           win_vld,
  output logic [SRC_W-1:0]               win_idx,
  output logic [NUM_SRC-1:0]             win_hot
);
  logic [PRIO_W-1:0] best_p;

  // Strictly-greater compare keeps the lowest index on a tie.
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    best_p  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!win_vld || prio[i] > best_p)) begin
        win_vld = 1'b1;
        win_idx = SRC_W'(i);
        best_p  = prio[i];
      end
    end
    win_hot = win_vld ? (NUM_SRC'(1) << win_idx) : '0;
  end
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_sel,
  input  logic                           bus_we,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [NUM_SRC-1:0]             pend,
  input  logic [NUM_SRC-1:0]             win_hot,
  input  logic [SRC_W-1:0]               win_idx,
  input  logic                           agree,
  output logic [NUM_SRC-1:0]             mask_q,
  output logic [NUM_SRC-1:0]             edge_q,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q,
  output logic                           agree_set,
  output logic                           win_rd,
  output logic [DATA_W-1:0]              bus_rdata
);
  logic wr, rd;
  logic [NUM_SRC-1:0] cfg_hit;
  logic [DATA_W-1:0]  rd_mux;
  logic unused_wdata;

  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;
  assign unused_wdata = ^bus_wdata;

  assign agree_set = wr && (bus_addr == ADDR_W'(A_CTRL)) && bus_wdata[0];
  assign win_rd    = rd && ((bus_addr == ADDR_W'(A_WIN_HOT)) ||
                            (bus_addr == ADDR_W'(A_WIN_IDX)));

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else if (wr && bus_addr == ADDR_W'(A_MASK)) mask_q <= bus_wdata[NUM_SRC-1:0];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cfg
    assign cfg_hit[i] = (bus_addr == ADDR_W'(A_CFG_BASE + i));
    always_ff @(posedge clk) begin
      if (rst) begin
        edge_q[i] <= 1'b0;
        prio_q[i] <= '0;
      end else if (wr && cfg_hit[i]) begin
        edge_q[i] <= bus_wdata[CFG_EDGE];
        prio_q[i] <= bus_wdata[CFG_EDGE-1:CFG_PRIO_LO];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_MASK))    rd_mux = DATA_W'(mask_q);
    if (bus_addr == ADDR_W'(A_WIN_HOT)) rd_mux = DATA_W'(win_hot);
    if (bus_addr == ADDR_W'(A_WIN_IDX)) rd_mux = DATA_W'(win_idx);
    if (bus_addr == ADDR_W'(A_CTRL))    rd_mux = DATA_W'(agree);
    if (bus_addr == ADDR_W'(A_PEND))    rd_mux = DATA_W'(pend);
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cfg_hit[i]) rd_mux = DATA_W'({edge_q[i], prio_q[i], 1'b0});
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  // R10: read data is not disturbed by writes or idle cycles
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rd) |-> $stable(bus_rdata));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  logic [NUM_SRC-1:0]             pend, mask_q, edge_q, clr_req, win_hot, hot_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [SRC_W-1:0]               win_idx, idx_q;
  logic                           win_vld, agree_q, agree_set, win_rd, release_ok;

  prio_irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk, .rst, .bus_sel, .bus_we, .bus_addr, .bus_wdata,
    .pend, .win_hot(hot_q), .win_idx(idx_q), .agree(agree_q),
    .mask_q, .edge_q, .prio_q, .agree_set, .win_rd, .bus_rdata);

  prio_irq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk, .rst, .src_in, .edge_sel(edge_q), .clr_req, .pend);

  prio_irq_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .elig(pend & ~mask_q), .prio(prio_q), .win_vld, .win_idx, .win_hot);

  // Only the published edge winner is cleared by a winner-word read.
  assign clr_req    = (win_rd && irq_o) ? (hot_q & edge_q) : '0;
  assign release_ok = agree_q && irq_o && ((hot_q & pend & ~mask_q) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b0;
      hot_q   <= '0;
      idx_q   <= '0;
      agree_q <= 1'b0;
    end else begin
      if (agree_set)                          agree_q <= 1'b1;
      else if (agree_q && (!irq_o || release_ok)) agree_q <= 1'b0;

      if (irq_o) begin
        if (release_ok) begin
          irq_o <= 1'b0;
          hot_q <= '0;
          idx_q <= '0;
        end
      end else if (win_vld) begin
        irq_o <= 1'b1;
        hot_q <= win_hot;
        idx_q <= win_idx;
      end
    end
  end

  // R5: a held request publishes exactly one source
  p_one_winner_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($countones(hot_q) == 1));
  // R6: winner words frozen while the request is held
  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_o && $past(irq_o)) |-> ($stable(hot_q) && $stable(idx_q)));
  // R7: the output only falls through the agreement bit
  p_fall_agree_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> ($past(agree_q) && hot_q == '0));
  // R8: an idle agreement bit clears itself
  p_agree_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (agree_q && !irq_o && !agree_set) |=> !agree_q);
  // R9: a masked source never wins
  p_no_masked_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (($past(mask_q) & hot_q) == '0));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  localparam int NS = 16;
  localparam logic [7:0] A_MASK = 8'h00, A_HOT = 8'h01, A_IDX = 8'h02,
                         A_CTRL = 8'h03, A_PEND = 8'h04, A_CFG = 8'h10;

  logic clk = 1'b0, rst = 1'b1;
  logic [NS-1:0] src_in = '0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rd_val;
  logic irq_o;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl dut_i (.clk, .rst, .src_in, .bus_sel, .bus_we, .bus_addr,
                       .bus_wdata, .bus_rdata, .irq_o);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    rd_val = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cfgw(bit edg, int p);
    return (32'(edg) << 5) | (32'(p) << 1);
  endfunction

  task automatic cleanup();
    src_in = '0;
    wr(A_MASK, 32'hFFFF);
    wr(A_CTRL, 32'h1);
    idle(4);
    for (int i = 0; i < NS; i++) wr(A_CFG + 8'(i), 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 irq", 32'(irq_o), 0);
    rd(A_MASK); chk("R1 mask", rd_val, 32'h0000FFFF);
    rd(A_CFG + 8'd3); chk("R1 cfg", rd_val, 0);
    rd(A_HOT); chk("R1 hot", rd_val, 0);
    rd(A_IDX); chk("R1 idx", rd_val, 0);
    rd(A_CTRL); chk("R1 ctrl", rd_val, 0);
  endtask

  task automatic t_cfg();
    wr(A_CFG + 8'd5, 32'hFFFF_FFFF);
    rd(A_CFG + 8'd5); chk("R2 cfg bits", rd_val, 32'h3E);
    rd(8'h08); chk("R10 unmapped", rd_val, 0);
    wr(A_CFG + 8'd5, 0);
    rd(A_CFG + 8'd5); chk("R2 cfg clear", rd_val, 0);
  endtask

  task automatic t_level_mask();
    wr(A_CFG + 8'd2, cfgw(0, 3));
    src_in[2] = 1'b1;
    idle(4);
    chk("R9 masked no irq", 32'(irq_o), 0);
    rd(A_PEND); chk("R9 pend shown", rd_val, 32'h4);
    wr(A_MASK, 32'hFFFB);
    idle(3);
    chk("R5 irq", 32'(irq_o), 1);
    rd(A_HOT); chk("R5 hot", rd_val, 32'h4);
    rd(A_IDX); chk("R5 idx", rd_val, 2);
    rd(A_PEND); chk("R3 level kept", rd_val, 32'h4);
    wr(A_CTRL, 32'h1);
    idle(3);
    rd(A_CTRL); chk("R8 agree waits", rd_val, 1);
    chk("R8 irq held", 32'(irq_o), 1);
    src_in[2] = 1'b0;
    idle(4);
    chk("R7 irq released", 32'(irq_o), 0);
    rd(A_CTRL); chk("R8 self clear", rd_val, 0);
    rd(A_HOT); chk("R7 hot cleared", rd_val, 0);
    cleanup();
  endtask

  task automatic t_priority();
    wr(A_CFG + 8'd1, cfgw(0, 2));
    wr(A_CFG + 8'd6, cfgw(0, 9));
    wr(A_CFG + 8'd9, cfgw(0, 9));
    wr(A_CFG + 8'd12, cfgw(0, 15));
    wr(A_MASK, 32'hFFFF & ~32'h1242);
    src_in[1] = 1'b1; src_in[6] = 1'b1; src_in[9] = 1'b1;
    idle(4);
    rd(A_IDX); chk("R5 tie lowest", rd_val, 6);
    src_in[12] = 1'b1;
    idle(4);
    rd(A_IDX); chk("R6 frozen idx", rd_val, 6);
    rd(A_HOT); chk("R6 frozen hot", rd_val, 32'h40);
    wr(A_MASK, 32'hFFFF & ~32'h1202);
    wr(A_CTRL, 32'h1);
    idle(5);
    chk("R7 rearm irq", 32'(irq_o), 1);
    rd(A_IDX); chk("R7 new winner", rd_val, 12);
    cleanup();
    chk("R7 idle after cleanup", 32'(irq_o), 0);
  endtask

  task automatic t_edge();
    wr(A_CFG + 8'd3, cfgw(1, 5));
    wr(A_MASK, 32'hFFF7);
    @(negedge clk); src_in[3] = 1'b1;
    @(negedge clk); src_in[3] = 1'b0;
    idle(3);
    chk("R4 edge irq", 32'(irq_o), 1);
    wr(A_CTRL, 32'h1);
    idle(3);
    rd(A_CTRL); chk("R8 edge agree waits", rd_val, 1);
    chk("R8 edge irq held", 32'(irq_o), 1);
    rd(A_IDX); chk("R4 idx", rd_val, 3);
    idle(4);
    chk("R7 edge released", 32'(irq_o), 0);
    rd(A_PEND); chk("R4 read cleared", rd_val, 0);
    // second pulse, clear through one-hot read
    @(negedge clk); src_in[3] = 1'b1;
    @(negedge clk); src_in[3] = 1'b0;
    idle(3);
    rd(A_HOT); chk("R4 hot", rd_val, 32'h8);
    rd(A_PEND); chk("R4 hot read cleared", rd_val, 0);
    // rising edge coincident with a read clear
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_IDX; src_in[3] = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; src_in[3] = 1'b0;
    rd(A_PEND); chk("R4 rise beats clear", rd_val, 32'h8);
    rd(A_IDX);
    wr(A_CTRL, 32'h1);
    idle(4);
    chk("R7 final release", 32'(irq_o), 0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_level_mask();
    t_priority();
    t_edge();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule